// File: doc/BRIEF.md
# Converter Synchronization and Data-Ready Sequencer

This block is the digital control that lines up the output timing of a multi-channel sigma-delta converter with an external, active-low synchronization pulse. The pulse is brought onto the master clock through a flop chain. While it is held low, the block stops conversion and holds every channel's decimation-filter counters in clear. When the pulse is released, the block counts conversion-period ticks while the filter settles. It then declares the data valid.

Two output formats are supported. In strobe format, an active-low ready flag stays high from the sync assertion until settling has finished. In frame format, a gate forces the serial data line low for that same span. A clock-loss input marks the data as untrustworthy until a complete new sync pulse has been applied. All channels share one sequencer, so their clears and their valid indication move together.

Top module: `conv_sync_seq`

## Requirements
- R1: The sync input passes through a two-flop synchroniser. Outputs react to a change that is sampled on one clock edge after the following edge, and not before.
- R2: A low glitch on the sync input that does not span a rising clock edge has no effect on any output.
- R3: While the synchronised sync is low, every bit of `ch_clear` is 1. `clear_pulse` is 1 for exactly the first cycle of that low phase.
- R4: In strobe format (`fmt_frame`=0), `ready_n` is 1 from the synchronised sync fall through settling. It goes to 0 on the edge that samples the 129th tick counted after release.
- R5: In frame format (`fmt_frame`=1), `data_gate` is 0 from the synchronised sync fall through settling. It goes to 1 on the edge that samples the 128th tick counted after release.
- R6: The settling count advances only on cycles where `period_tick` is 1. Ticks received while sync is low are not counted.
- R7: A new sync pulse during settling restarts the count from zero.
- R8: A 1 on `clk_lost` forces the not-ready indication on the next cycle. The indication stays until a full sync pulse followed by a complete settling period.
- R9: After reset the block is not ready and settles as if a sync pulse had just been released.
- R10: In strobe format `data_gate` is held at 1. In frame format `ready_n` is held at 1. The format select takes effect combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_n_in | input | 1 | Asynchronous active-low synchronization pulse |
| fmt_frame | input | 1 | 0 selects strobe format, 1 selects frame format |
| period_tick | input | 1 | One-cycle pulse per conversion period |
| clk_lost | input | 1 | Clock interruption indication |
| ready_n | output | 1 | Active-low data-ready flag (strobe format) |
| data_gate | output | 1 | 1 lets the serial data through, 0 forces it low |
| clear_pulse | output | 1 | One-cycle strobe on the synchronised sync fall |
| ch_clear | output | NUM_CH | Per-channel filter counter clear, held while sync is low |

## Verification
The checker watches every cycle for these properties:
- a clear strobe always lasts one cycle and coincides with a full set of channel clears and the not-ready indication;
- readiness is only ever reached on a cycle just after a tick;
- a clock-loss indication always leaves the block not ready on the next cycle;
- the settling counter never exceeds its bound.

The exact settling lengths of 129 and 128 ticks can only be shown by the bench's scenarios. The same holds for the two-edge synchroniser latency, glitch rejection, the restart on a resync, the lock-out after clock loss and the post-reset settling.

// File: rtl/conv_sync_pkg.sv
// Package: shared types and constants of the synchronization sequencer.
// Assumes: settling lengths are at least 2 ticks.
package conv_sync_pkg;

    // Sequencer states: settling, data valid, held by sync, locked out.
    typedef enum logic [1:0] {
        SQ_SETTLE = 2'd0,
        SQ_VALID  = 2'd1,
        SQ_HALT   = 2'd2,
        SQ_LOST   = 2'd3
    } seq_state_t;

    // Settling lengths in conversion periods for each format.
    localparam int unsigned STROBE_SETTLE = 129;
    localparam int unsigned FRAME_SETTLE  = 128;

    // Larger of two lengths, used to size counters.
    function automatic int unsigned max_len(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cs_sync_edge.sv
// Module: cs_sync_edge
// Brings the asynchronous active-low sync input onto the master clock through
// a STAGES-deep flop chain and flags the falling edge of the synchronised value.
// Assumes: STAGES >= 2; the chain resets to the released (high) level.
module cs_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_n,
    output logic sync_low,
    output logic fall_pulse
);

    logic [STAGES-1:0] chain_q;
    logic              last_q;

    // Shift the raw input through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], async_n};
    end

    // Remember the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b1;
        else        last_q <= chain_q[STAGES-1];
    end

    // Level and edge decode of the synchronised value.
    always_comb begin
        sync_low   = ~chain_q[STAGES-1];
        fall_pulse = last_q & ~chain_q[STAGES-1];
    end

endmodule

// File: rtl/cs_settle_ctl.sv
// Module: cs_settle_ctl
// Tracks filter settling after a sync release. The counter advances only on
// conversion ticks, restarts on any new sync, and a clock-loss indication
// locks the block out until a sync pulse is seen.
// Assumes: sync_low is already synchronised; the length is picked from the live format.
module cs_settle_ctl
    import conv_sync_pkg::*;
#(
    parameter int unsigned STROBE_LEN = STROBE_SETTLE,
    parameter int unsigned FRAME_LEN  = FRAME_SETTLE,
    parameter int unsigned CW         = $clog2(max_len(STROBE_LEN, FRAME_LEN))
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync_low,
    input  logic          fmt_frame,
    input  logic          period_tick,
    input  logic          clk_lost,
    output logic          valid,
    output logic [CW-1:0] cnt_o
);

    localparam logic [CW-1:0] STROBE_LAST = CW'(STROBE_LEN - 1);
    localparam logic [CW-1:0] FRAME_LAST  = CW'(FRAME_LEN - 1);

    seq_state_t    state_q;
    logic [CW-1:0] cnt_q;
    logic          last_tick;

    // Detect the tick that completes the settling period.
    always_comb begin
        last_tick = (cnt_q == (fmt_frame ? FRAME_LAST : STROBE_LAST));
    end

    // Sequencer: sync dominates, then clock loss, then normal settling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_SETTLE;
            cnt_q   <= '0;
        end else if (sync_low) begin
            state_q <= SQ_HALT;
            cnt_q   <= '0;
        end else if (clk_lost) begin
            state_q <= SQ_LOST;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                SQ_HALT: begin
                    state_q <= SQ_SETTLE;
                    cnt_q   <= '0;
                end
                SQ_SETTLE: begin
                    if (period_tick) begin
                        if (last_tick) begin
                            state_q <= SQ_VALID;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: begin
                    state_q <= state_q;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    // Valid data only in the valid state and never while sync is low.
    always_comb begin
        valid = (state_q == SQ_VALID) && !sync_low;
        cnt_o = cnt_q;
    end

endmodule

// File: rtl/cs_out_fmt.sv
// Module: cs_out_fmt
// Maps the sequencer's valid flag onto the selected output format and fans
// the filter clear out to every channel.
// Assumes: all channels share the master clock and the sync control.
module cs_out_fmt #(
    parameter int NUM_CH = 8
) (
    input  logic              valid,
    input  logic              fmt_frame,
    input  logic              sync_low,
    input  logic              fall_pulse,
    output logic              ready_n,
    output logic              data_gate,
    output logic              clear_pulse,
    output logic [NUM_CH-1:0] ch_clear
);

    // Format decode: each format keeps the other's indication inactive.
    always_comb begin
        ready_n     = fmt_frame ? 1'b1 : ~valid;
        data_gate   = fmt_frame ? valid : 1'b1;
        clear_pulse = fall_pulse;
    end

    // One clear line per channel, all driven by the same sequencer.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        assign ch_clear[ch] = sync_low;
    end

endmodule

// File: rtl/conv_sync_seq.sv
// Module: conv_sync_seq (top)
// Synchronization and data-ready sequencer for a multi-channel converter:
// synchronises the sync pulse, clears the filter counters, waits out filter
// settling and signals valid data in strobe or frame format.
// Assumes: period_tick is a one-cycle pulse on the master clock.
module conv_sync_seq
    import conv_sync_pkg::*;
#(
    parameter int          NUM_CH      = 8,
    parameter int          SYNC_STAGES = 2,
    parameter int unsigned STROBE_LEN  = STROBE_SETTLE,
    parameter int unsigned FRAME_LEN   = FRAME_SETTLE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_n_in,
    input  logic              fmt_frame,
    input  logic              period_tick,
    input  logic              clk_lost,
    output logic              ready_n,
    output logic              data_gate,
    output logic              clear_pulse,
    output logic [NUM_CH-1:0] ch_clear
);

    localparam int unsigned MAX_LEN = max_len(STROBE_LEN, FRAME_LEN);
    localparam int unsigned CW      = $clog2(MAX_LEN);

    logic          sync_low;
    logic          fall_pulse;
    logic          valid;
    logic [CW-1:0] settle_cnt;

    cs_sync_edge #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_n    (sync_n_in),
        .sync_low   (sync_low),
        .fall_pulse (fall_pulse)
    );

    cs_settle_ctl #(
        .STROBE_LEN (STROBE_LEN),
        .FRAME_LEN  (FRAME_LEN),
        .CW         (CW)
    ) u_settle (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_low    (sync_low),
        .fmt_frame   (fmt_frame),
        .period_tick (period_tick),
        .clk_lost    (clk_lost),
        .valid       (valid),
        .cnt_o       (settle_cnt)
    );

    cs_out_fmt #(
        .NUM_CH (NUM_CH)
    ) u_fmt (
        .valid       (valid),
        .fmt_frame   (fmt_frame),
        .sync_low    (sync_low),
        .fall_pulse  (fall_pulse),
        .ready_n     (ready_n),
        .data_gate   (data_gate),
        .clear_pulse (clear_pulse),
        .ch_clear    (ch_clear)
    );

endmodule

// File: rtl/conv_sync_seq_chk.sv
// Module: conv_sync_seq_chk
// Property checker bound to conv_sync_seq; observes ports and the settling count.
// Assumes: connected through the bind statement at the end of this file.
module conv_sync_seq_chk #(
    parameter int          NUM_CH  = 8,
    parameter int unsigned CW      = 8,
    parameter int unsigned MAX_LEN = 129
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fmt_frame,
    input logic              period_tick,
    input logic              clk_lost,
    input logic              ready_n,
    input logic              data_gate,
    input logic              clear_pulse,
    input logic [NUM_CH-1:0] ch_clear,
    input logic [CW-1:0]     settle_cnt
);

    assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clear_pulse |=> !clear_pulse);

    assert_pulse_clears_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clear_pulse |-> (&ch_clear));

    // R4 and R5: the fall of sync always shows as not ready in the active format.
    assert_pulse_notready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clear_pulse |-> (fmt_frame ? !data_gate : ready_n));

    assert_ready_after_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ready_n) && $stable(fmt_frame) && !fmt_frame) |-> $past(period_tick));

    assert_gate_after_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(data_gate) && $stable(fmt_frame) && fmt_frame) |-> $past(period_tick));

    assert_lost_notready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clk_lost |=> (fmt_frame ? !data_gate : ready_n));

    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        settle_cnt < CW'(MAX_LEN));

endmodule

bind conv_sync_seq conv_sync_seq_chk #(
    .NUM_CH  (NUM_CH),
    .CW      (CW),
    .MAX_LEN (MAX_LEN)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fmt_frame   (fmt_frame),
    .period_tick (period_tick),
    .clk_lost    (clk_lost),
    .ready_n     (ready_n),
    .data_gate   (data_gate),
    .clear_pulse (clear_pulse),
    .ch_clear    (ch_clear),
    .settle_cnt  (settle_cnt)
);

// File: tb/conv_sync_seq_test.sv
// Bench: scoreboard. The driver pushes expected output items just after a rising
// edge; the monitor pops and compares them on the following falling edge.
module conv_sync_seq_test;

    localparam int NUM_CH = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sync_n_in = 1'b1;
    logic              fmt_frame = 1'b0;
    logic              period_tick = 1'b0;
    logic              clk_lost = 1'b0;
    logic              ready_n;
    logic              data_gate;
    logic              clear_pulse;
    logic [NUM_CH-1:0] ch_clear;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        string tag;
        logic  rn;
        logic  gate;
        logic  pulse;
        logic  clr;
    } exp_t;

    exp_t exp_q[$];

    always #5 clk = ~clk;

    conv_sync_seq #(.NUM_CH(NUM_CH)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_n_in   (sync_n_in),
        .fmt_frame   (fmt_frame),
        .period_tick (period_tick),
        .clk_lost    (clk_lost),
        .ready_n     (ready_n),
        .data_gate   (data_gate),
        .clear_pulse (clear_pulse),
        .ch_clear    (ch_clear)
    );

    // Monitor: compare the design's outputs against the queued expectation.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            logic [NUM_CH-1:0] clr_exp;
            e = exp_q.pop_front();
            clr_exp = e.clr ? '1 : '0;
            n_checks++;
            if (ready_n !== e.rn || data_gate !== e.gate ||
                clear_pulse !== e.pulse || ch_clear !== clr_exp) begin
                n_fail++;
                $display("FAIL %s: ready_n=%b/%b data_gate=%b/%b clear_pulse=%b/%b ch_clear=%h/%h",
                         e.tag, ready_n, e.rn, data_gate, e.gate,
                         clear_pulse, e.pulse, ch_clear, clr_exp);
            end
        end
    end

    // Advance to just after the next rising edge.
    task automatic cyc(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    // Push one expected output item for this cycle.
    task automatic expect_out(input string tag, input logic rn, input logic gate,
                              input logic pulse, input logic clr);
        exp_t e;
        e.tag = tag; e.rn = rn; e.gate = gate; e.pulse = pulse; e.clr = clr;
        exp_q.push_back(e);
    endtask

    // Issue n conversion ticks, one per cycle, separated by idle cycles.
    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            period_tick = 1'b1;
            cyc();
            period_tick = 1'b0;
            cyc();
        end
    endtask

    // Full sync pulse, then wait until the sequencer is settling.
    task automatic do_sync();
        sync_n_in = 1'b0;
        cyc(3);
        sync_n_in = 1'b1;
        cyc(4);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        cyc(5);
        rst_n = 1'b1;
        cyc();
        // R9: not ready after reset, settles like a fresh release (strobe: 129).
        expect_out("R9 reset state", 1, 1, 0, 0);
        cyc();
        ticks(128);
        expect_out("R9 128 ticks after reset", 1, 1, 0, 0);
        ticks(1);
        expect_out("R9 ready after 129 ticks", 0, 1, 0, 0);
        cyc();

        // R1: one edge after sync falls nothing changes yet.
        sync_n_in = 1'b0;
        cyc();
        expect_out("R1 one edge latency", 0, 1, 0, 0);
        cyc();
        expect_out("R3 R4 clear pulse and not ready", 1, 1, 1, 1);
        cyc();
        expect_out("R3 clear held, pulse gone", 1, 1, 0, 1);
        cyc();
        ticks(5); // R6: ignored while sync is low
        expect_out("R6 ticks during sync low", 1, 1, 0, 1);
        sync_n_in = 1'b1;
        cyc(4);
        expect_out("R4 settling after release", 1, 1, 0, 0);
        cyc();
        ticks(128);
        expect_out("R4 R6 not ready at 128 ticks", 1, 1, 0, 0);
        ticks(1);
        expect_out("R4 ready at 129 ticks", 0, 1, 0, 0);
        cyc();

        // R2: glitch that never spans a rising edge.
        sync_n_in = 1'b0;
        #3;
        sync_n_in = 1'b1;
        cyc();
        expect_out("R2 glitch ignored a", 0, 1, 0, 0);
        cyc();
        expect_out("R2 glitch ignored b", 0, 1, 0, 0);
        cyc();
        expect_out("R2 glitch ignored c", 0, 1, 0, 0);
        cyc();

        // R10: switch to frame format while data is valid.
        fmt_frame = 1'b1;
        expect_out("R10 frame format valid", 1, 1, 0, 0);
        cyc();

        // R5: frame format sync and settling.
        sync_n_in = 1'b0;
        cyc(2);
        expect_out("R5 gate low on sync", 1, 0, 1, 1);
        cyc();
        sync_n_in = 1'b1;
        cyc(4);
        expect_out("R5 gate low while settling", 1, 0, 0, 0);
        cyc();
        ticks(127);
        expect_out("R5 gate low at 127 ticks", 1, 0, 0, 0);
        ticks(1);
        expect_out("R5 gate open at 128 ticks", 1, 1, 0, 0);
        cyc();

        // R7: resync in the middle of settling restarts the count.
        do_sync();
        ticks(60);
        expect_out("R7 mid settling", 1, 0, 0, 0);
        cyc();
        do_sync();
        ticks(127);
        expect_out("R7 restarted, 127 ticks", 1, 0, 0, 0);
        ticks(1);
        expect_out("R7 restarted, 128 ticks", 1, 1, 0, 0);
        cyc();

        // R8: clock loss locks out until a full sync pulse.
        clk_lost = 1'b1;
        cyc();
        clk_lost = 1'b0;
        expect_out("R8 not ready after clock loss", 1, 0, 0, 0);
        cyc();
        ticks(200);
        expect_out("R8 ticks do not recover", 1, 0, 0, 0);
        cyc();
        do_sync();
        ticks(127);
        expect_out("R8 settling after resync", 1, 0, 0, 0);
        ticks(1);
        expect_out("R8 recovered after resync", 1, 1, 0, 0);
        cyc();

        // R10: back to strobe format while valid.
        fmt_frame = 1'b0;
        expect_out("R10 strobe format valid", 0, 1, 0, 0);
        cyc(2);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule